// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block sits in the issue stage of an in-order pipeline that feeds four functional units: integer, floating-point add, floating-point multiply and floating-point divide. It keeps a busy flag for each unit and a write-pending flag for each architectural register. Every cycle it looks at the decoded instruction offered by decode (unit class, destination, two sources, each with an enable) and decides whether that instruction can leave for its unit.

The decision covers three hazards. A structural hazard is a busy target unit. A read-after-write hazard is an enabled source whose register still waits for a result. A write-after-write hazard is an enabled destination that already has a write in flight. Write-after-read needs no check, because instructions leave in program order and so read their operands before any younger writer can be dispatched. Dispatch uses a valid/ready handshake. On dispatch the block marks the destination pending and the unit busy. Two writeback ports, one integer and one floating-point, clear pending flags, and a done pulse from each unit clears its busy flag.

Top module: `issue_scoreboard`

## Requirements
- R1: Each unit (code 0 integer, 1 FP add, 2 FP multiply, 3 FP divide; `busy_o` bit n is unit code n) becomes busy in the cycle after an instruction dispatches to it, and becomes free in the cycle after its `fu_done` bit pulses while it is busy.
- R2: A dispatch with `in_dst_en` high sets `pending_o[in_dst]` in the following cycle; a dispatch with `in_dst_en` low sets no pending flag.
- R3: Each writeback port with its valid high clears the pending flag at its index in the following cycle; both ports may clear different registers, or the same register, in one cycle.
- R4: `hazard_o[0]` (structural) is high, and `in_ready` low, whenever the unit selected by `in_fu` is busy.
- R5: `hazard_o[1]` (read-after-write) is high, and `in_ready` low, whenever an enabled source register has its pending flag set; a disabled source is never checked.
- R6: `hazard_o[2]` (write-after-write) is high, and `in_ready` low, whenever the destination is enabled and its pending flag is already set.
- R7: A destination register that an earlier dispatched instruction reads, and that is not pending, causes no stall.
- R8: `in_ready` is high exactly when no hazard bit is set, and depends only on the registered flags, so a writeback or done pulse in the same cycle does not release a stall until the next cycle; `dispatch_o` equals `in_valid` and `in_ready`, so at most one instruction leaves per cycle and a stalled instruction is held.
- R9: When a dispatch sets a register's pending flag in the same cycle that a writeback port clears that register, the flag ends up set.
- R10: Synchronous reset clears every pending flag and every busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decode offers an instruction |
| in_ready | output | 1 | No hazard; the offered instruction may dispatch |
| in_fu | input | 2 | Target unit code (0 int, 1 add, 2 mul, 3 div) |
| in_dst | input | IDX_W | Destination register index |
| in_dst_en | input | 1 | Instruction writes a register |
| in_src1 | input | IDX_W | First source register index |
| in_src1_en | input | 1 | First source is used |
| in_src2 | input | IDX_W | Second source register index |
| in_src2_en | input | 1 | Second source is used |
| fu_done | input | 4 | Per-unit pulse: unit has finished and is free |
| wb_int_valid | input | 1 | Integer writeback port active |
| wb_int_idx | input | IDX_W | Register written by the integer port |
| wb_fp_valid | input | 1 | FP writeback port active |
| wb_fp_idx | input | IDX_W | Register written by the FP port |
| dispatch_o | output | 1 | Instruction leaves this cycle |
| hazard_o | output | 3 | Bit 0 structural, bit 1 read-after-write, bit 2 write-after-write |
| busy_o | output | 4 | Busy flag per unit |
| pending_o | output | NUM_REGS | Write-pending flag per register |

## Verification
The busy-clear property assumes a done pulse arrives only for a unit that is busy, since that is the only case in which the pulse changes state; the writeback-clear property excludes the cycle in which a dispatch sets the same register. The stimulus keeps within the interface by holding `in_valid` low during reset and driving register indices below `NUM_REGS`, while done pulses and writebacks for idle units and registers are still sent at random to show they leave the flags alone. Directed sequences build each hazard and the set-versus-clear collision on purpose, and a long random run over eight registers compares every output against a flag model kept in the bench.

// File: rtl/isb_pkg.sv
package isb_pkg;

    localparam int NUM_FU = 4;
    localparam int FU_W   = $clog2(NUM_FU);

    typedef enum logic [FU_W-1:0] {
        FU_INT = 2'd0,
        FU_ADD = 2'd1,
        FU_MUL = 2'd2,
        FU_DIV = 2'd3
    } fu_class_e;

    typedef struct packed {
        logic waw;
        logic raw;
        logic structural;
    } hazard_t;

    function automatic logic [NUM_FU-1:0] fu_onehot(input fu_class_e c);
        logic [NUM_FU-1:0] v;
        v = '0;
        v[c] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/isb_pending_table.sv
module isb_pending_table #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_a_en,
    input  logic [IDX_W-1:0]    clr_a_idx,
    input  logic                clr_b_en,
    input  logic [IDX_W-1:0]    clr_b_idx,
    output logic [NUM_REGS-1:0] pending
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic hit_set;
        logic hit_clr;

        always_comb begin
            hit_set = set_en && (set_idx == IDX_W'(r));
            hit_clr = (clr_a_en && (clr_a_idx == IDX_W'(r))) ||
                      (clr_b_en && (clr_b_idx == IDX_W'(r)));
        end

        // A new pending write outranks a writeback in the same cycle.
        always_ff @(posedge clk) begin
            if (rst) begin
                pending[r] <= 1'b0;
            end else if (hit_set) begin
                pending[r] <= 1'b1;
            end else if (hit_clr) begin
                pending[r] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/isb_busy_table.sv
module isb_busy_table
    import isb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              claim_en,
    input  fu_class_e         claim_fu,
    input  logic [NUM_FU-1:0] release_vec,
    output logic [NUM_FU-1:0] busy
);

    logic [NUM_FU-1:0] claim_vec;

    always_comb begin
        claim_vec = claim_en ? fu_onehot(claim_fu) : '0;
    end

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        always_ff @(posedge clk) begin
            if (rst) begin
                busy[u] <= 1'b0;
            end else if (claim_vec[u]) begin
                busy[u] <= 1'b1;
            end else if (release_vec[u]) begin
                busy[u] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/isb_hazard_check.sv
module isb_hazard_check
    import isb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] pending,
    input  logic [NUM_FU-1:0]   busy,
    input  fu_class_e           fu,
    input  logic [IDX_W-1:0]    dst,
    input  logic                dst_en,
    input  logic [IDX_W-1:0]    src1,
    input  logic                src1_en,
    input  logic [IDX_W-1:0]    src2,
    input  logic                src2_en,
    output hazard_t             hazard
);

    logic raw_1;
    logic raw_2;

    // Write-after-read is not tested: in-order issue reads before any
    // younger writer can leave.
    always_comb begin
        raw_1             = src1_en && pending[src1];
        raw_2             = src2_en && pending[src2];
        hazard.structural = busy[fu];
        hazard.raw        = raw_1 || raw_2;
        hazard.waw        = dst_en && pending[dst];
    end

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
    import isb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [1:0]          in_fu,
    input  logic [IDX_W-1:0]    in_dst,
    input  logic                in_dst_en,
    input  logic [IDX_W-1:0]    in_src1,
    input  logic                in_src1_en,
    input  logic [IDX_W-1:0]    in_src2,
    input  logic                in_src2_en,
    input  logic [3:0]          fu_done,
    input  logic                wb_int_valid,
    input  logic [IDX_W-1:0]    wb_int_idx,
    input  logic                wb_fp_valid,
    input  logic [IDX_W-1:0]    wb_fp_idx,
    output logic                dispatch_o,
    output logic [2:0]          hazard_o,
    output logic [3:0]          busy_o,
    output logic [NUM_REGS-1:0] pending_o
);

    fu_class_e         fu_sel;
    hazard_t           haz;
    logic [NUM_REGS-1:0] pend_q;
    logic [NUM_FU-1:0] busy_q;
    logic              fire;

    always_comb begin
        fu_sel = fu_class_e'(in_fu);
    end

    isb_hazard_check #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_check (
        .pending (pend_q),
        .busy    (busy_q),
        .fu      (fu_sel),
        .dst     (in_dst),
        .dst_en  (in_dst_en),
        .src1    (in_src1),
        .src1_en (in_src1_en),
        .src2    (in_src2),
        .src2_en (in_src2_en),
        .hazard  (haz)
    );

    always_comb begin
        in_ready = (haz == '0);
        fire     = in_valid && in_ready;
    end

    isb_pending_table #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_pend (
        .clk       (clk),
        .rst       (rst),
        .set_en    (fire && in_dst_en),
        .set_idx   (in_dst),
        .clr_a_en  (wb_int_valid),
        .clr_a_idx (wb_int_idx),
        .clr_b_en  (wb_fp_valid),
        .clr_b_idx (wb_fp_idx),
        .pending   (pend_q)
    );

    isb_busy_table u_busy (
        .clk         (clk),
        .rst         (rst),
        .claim_en    (fire),
        .claim_fu    (fu_sel),
        .release_vec (fu_done),
        .busy        (busy_q)
    );

    always_comb begin
        dispatch_o = fire;
        hazard_o   = haz;
        busy_o     = busy_q;
        pending_o  = pend_q;
    end

endmodule

// File: rtl/isb_checker.sv
module isb_checker #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic [1:0]          in_fu,
    input logic [IDX_W-1:0]    in_dst,
    input logic                in_dst_en,
    input logic [IDX_W-1:0]    in_src1,
    input logic                in_src1_en,
    input logic [IDX_W-1:0]    in_src2,
    input logic                in_src2_en,
    input logic [3:0]          fu_done,
    input logic                wb_int_valid,
    input logic [IDX_W-1:0]    wb_int_idx,
    input logic                wb_fp_valid,
    input logic [IDX_W-1:0]    wb_fp_idx,
    input logic                dispatch_o,
    input logic [2:0]          hazard_o,
    input logic [3:0]          busy_o,
    input logic [NUM_REGS-1:0] pending_o
);

    logic set_hits_int;
    logic set_hits_fp;

    always_comb begin
        set_hits_int = dispatch_o && in_dst_en && (in_dst == wb_int_idx);
        set_hits_fp  = dispatch_o && in_dst_en && (in_dst == wb_fp_idx);
    end

    a_r1_busy_claim: assert property (@(posedge clk) disable iff (rst)
        dispatch_o |=> busy_o[$past(in_fu)]);

    for (genvar u = 0; u < 4; u++) begin : g_done
        a_r1_busy_release: assert property (@(posedge clk) disable iff (rst)
            (busy_o[u] && fu_done[u]) |=> !busy_o[u]);
    end

    a_r2_pending_set: assert property (@(posedge clk) disable iff (rst)
        (dispatch_o && in_dst_en) |=> pending_o[$past(in_dst)]);

    a_r3_int_clear: assert property (@(posedge clk) disable iff (rst)
        (wb_int_valid && !set_hits_int) |=> !pending_o[$past(wb_int_idx)]);

    a_r3_fp_clear: assert property (@(posedge clk) disable iff (rst)
        (wb_fp_valid && !set_hits_fp) |=> !pending_o[$past(wb_fp_idx)]);

    a_r4_structural: assert property (@(posedge clk) disable iff (rst)
        busy_o[in_fu] |-> (!in_ready && hazard_o[0]));

    a_r5_raw: assert property (@(posedge clk) disable iff (rst)
        ((in_src1_en && pending_o[in_src1]) || (in_src2_en && pending_o[in_src2]))
        |-> (!in_ready && hazard_o[1]));

    a_r6_waw: assert property (@(posedge clk) disable iff (rst)
        (in_dst_en && pending_o[in_dst]) |-> (!in_ready && hazard_o[2]));

    a_r8_handshake: assert property (@(posedge clk) disable iff (rst)
        dispatch_o |-> (in_valid && in_ready));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |-> !dispatch_o);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_hits_int || set_hits_fp) |=> pending_o[$past(in_dst)]);

    a_r10_reset: assert property (@(posedge clk)
        rst |=> (pending_o == '0 && busy_o == '0));

endmodule

bind issue_scoreboard isb_checker #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
) u_chk (.*);

// File: tb/issue_scoreboard_tb_top.sv
module issue_scoreboard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NR         = 8;
    localparam int IW         = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_ready;
    logic [1:0]    in_fu;
    logic [IW-1:0] in_dst;
    logic          in_dst_en;
    logic [IW-1:0] in_src1;
    logic          in_src1_en;
    logic [IW-1:0] in_src2;
    logic          in_src2_en;
    logic [3:0]    fu_done;
    logic          wb_int_valid;
    logic [IW-1:0] wb_int_idx;
    logic          wb_fp_valid;
    logic [IW-1:0] wb_fp_idx;
    logic          dispatch_o;
    logic [2:0]    hazard_o;
    logic [3:0]    busy_o;
    logic [NR-1:0] pending_o;

    int checks = 0;
    int fails  = 0;

    logic [NR-1:0] m_pend;
    logic [3:0]    m_busy;

    always #(CLK_PERIOD / 2) clk = ~clk;

    issue_scoreboard #(.NUM_REGS(NR), .IDX_W(IW)) dut_i (.*);

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 0; in_fu = 0; in_dst = 0; in_dst_en = 0;
        in_src1 = 0; in_src1_en = 0; in_src2 = 0; in_src2_en = 0;
        fu_done = 0; wb_int_valid = 0; wb_int_idx = 0;
        wb_fp_valid = 0; wb_fp_idx = 0;
    endtask

    task automatic offer(input int fu, input int dst, input bit den,
                         input int s1, input bit s1e, input int s2, input bit s2e);
        in_valid = 1; in_fu = 2'(fu); in_dst = IW'(dst); in_dst_en = den;
        in_src1 = IW'(s1); in_src1_en = s1e; in_src2 = IW'(s2); in_src2_en = s2e;
    endtask

    // Inputs are already driven; checks combinational outputs against the
    // model, advances one clock, then checks the registered flags.
    task automatic step();
        logic [2:0] eh;
        logic       er;
        logic       ed;
        #1;
        eh[0] = m_busy[in_fu];
        eh[1] = (in_src1_en && m_pend[in_src1]) || (in_src2_en && m_pend[in_src2]);
        eh[2] = in_dst_en && m_pend[in_dst];
        er    = (eh == 3'b000);
        ed    = in_valid && er;
        chk(hazard_o[0] === eh[0], "R4 structural", 32'(hazard_o[0]), 32'(eh[0]));
        chk(hazard_o[1] === eh[1], "R5 raw", 32'(hazard_o[1]), 32'(eh[1]));
        chk(hazard_o[2] === eh[2], "R6 waw", 32'(hazard_o[2]), 32'(eh[2]));
        chk(in_ready === er, "R8 ready", 32'(in_ready), 32'(er));
        chk(dispatch_o === ed, "R8 dispatch", 32'(dispatch_o), 32'(ed));
        for (int r = 0; r < NR; r++) begin
            if (ed && in_dst_en && in_dst == IW'(r)) m_pend[r] = 1'b1;
            else if ((wb_int_valid && wb_int_idx == IW'(r)) ||
                     (wb_fp_valid && wb_fp_idx == IW'(r))) m_pend[r] = 1'b0;
        end
        for (int u = 0; u < 4; u++) begin
            if (ed && in_fu == 2'(u)) m_busy[u] = 1'b1;
            else if (fu_done[u]) m_busy[u] = 1'b0;
        end
        @(posedge clk);
        #1;
        chk(pending_o === m_pend, "R2/R3 pending", 32'(pending_o), 32'(m_pend));
        chk(busy_o === m_busy, "R1 busy", 32'(busy_o), 32'(m_busy));
        idle_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        m_pend = '0;
        m_busy = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        chk(pending_o === '0, "R10 reset pending", 32'(pending_o), 0);
        chk(busy_o === '0, "R10 reset busy", 32'(busy_o), 0);
        chk(in_ready === 1'b1, "R10 ready after reset", 32'(in_ready), 1);

        // R2 / R1: int op writes r3
        offer(0, 3, 1, 0, 0, 0, 0); step();
        chk(pending_o[3] === 1'b1, "R2 r3 pending", 32'(pending_o[3]), 1);
        chk(busy_o[0] === 1'b1, "R1 int busy", 32'(busy_o[0]), 1);

        // R5: add reads r3; writeback and done in same cycle do not release (R8)
        offer(1, 4, 1, 3, 1, 0, 0);
        wb_int_valid = 1; wb_int_idx = 3; fu_done = 4'b0001;
        #1;
        chk(in_ready === 1'b0, "R5 raw stall", 32'(in_ready), 0);
        chk(hazard_o === 3'b010, "R5 raw code", 32'(hazard_o), 32'h2);
        step();
        chk(pending_o[3] === 1'b0 && busy_o[0] === 1'b0, "R3 cleared",
            32'({pending_o[3], busy_o[0]}), 0);
        // R5: disabled source is not checked
        offer(2, 5, 1, 3, 0, 3, 0); step();
        chk(pending_o[5] === 1'b1, "R2 r5 pending", 32'(pending_o[5]), 1);
        // R6 / R4
        offer(3, 5, 1, 0, 0, 0, 0); #1;
        chk(hazard_o === 3'b100, "R6 waw code", 32'(hazard_o), 32'h4);
        step();
        offer(2, 6, 1, 0, 0, 0, 0); #1;
        chk(hazard_o === 3'b001, "R4 structural code", 32'(hazard_o), 32'h1);
        step();
        // R2: no destination means no pending flag
        offer(0, 2, 0, 0, 0, 0, 0); step();
        chk(pending_o[2] === 1'b0, "R2 no dest", 32'(pending_o[2]), 0);
        fu_done = 4'b0001; step();
        // R9: late writeback of r7 collides with a new write of r7
        offer(0, 7, 1, 0, 0, 0, 0); wb_fp_valid = 1; wb_fp_idx = 7; step();
        chk(pending_o[7] === 1'b1, "R9 set wins", 32'(pending_o[7]), 1);
        fu_done = 4'b0001; step();
        // R7: add reads r2 and writes r1, then div writes r2 at once
        offer(1, 1, 1, 2, 1, 2, 1); step();
        offer(3, 2, 1, 0, 0, 0, 0); #1;
        chk(in_ready === 1'b1, "R7 no war stall", 32'(in_ready), 1);
        step();
        // R3: both ports clear in one cycle
        wb_int_valid = 1; wb_int_idx = 1; wb_fp_valid = 1; wb_fp_idx = 2; step();
        chk(pending_o[1] === 1'b0 && pending_o[2] === 1'b0, "R3 dual clear",
            32'(pending_o), 32'(m_pend));

        // random sweep
        for (int n = 0; n < 4000; n++) begin
            in_valid     = ($urandom % 4) != 0;
            in_fu        = 2'($urandom);
            in_dst       = IW'($urandom);
            in_dst_en    = ($urandom % 4) != 0;
            in_src1      = IW'($urandom);
            in_src1_en   = ($urandom % 2) != 0;
            in_src2      = IW'($urandom);
            in_src2_en   = ($urandom % 2) != 0;
            fu_done      = 4'($urandom) & 4'($urandom);
            wb_int_valid = ($urandom % 2) != 0;
            wb_int_idx   = IW'($urandom);
            wb_fp_valid  = ($urandom % 2) != 0;
            wb_fp_idx    = IW'($urandom);
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule